// File: doc/BRIEF.md
# Field Read/Write Reset Timing Monitor

This block watches the two pointer-reset strobes of a field memory: the strobe that restarts the write pointer at the start of a field and the strobe that restarts the read pointer. Each read-pointer reset asks which field the read will return. The monitor answers by measuring how many clock cycles have passed since the most recent write-pointer reset, and sorting that gap into one of three windows. A short gap means the earlier field is still read out (old data). A long gap means the field just written is read out (new data). The band in between gives data that cannot be predicted.

One cycle after each read reset, the monitor emits a one-cycle report with a two-bit class code. A report of the undetermined class also sets a sticky violation flag, which only a reset clears. A small state machine tracks whether any write reset has been seen since reset. A saturating counter holds the gap, and a combinational classifier turns the gap into the class code.

The state machine has two states. `ST_NOREF` is the state after reset, before any write-pointer reset. `ST_TRACK` holds once a write reset has been seen. The only transition is `ST_NOREF` to `ST_TRACK`, taken on the first write-reset strobe. `ST_TRACK` loops on itself until reset.

Top module: `frm_reset_monitor`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `rpt_valid_o` is 0, `viol_o` is 0 and `rpt_class_o` is 2'b00.
- R2: `rpt_valid_o` is high for exactly the one cycle after each cycle in which `rd_rst_i` is high, and low in every other cycle.
- R3: The gap is the number of clock edges from the cycle holding the most recent write strobe to the cycle holding the read strobe. A gap below `OLD_LIMIT` (default 70) reports class 2'b00 (old data).
- R4: A gap of at least `NEW_MIN` (default 600) reports class 2'b01 (new data).
- R5: A gap from `OLD_LIMIT` up to `NEW_MIN`-1 reports class 2'b10 (undetermined). This band includes gaps of exactly 70 and 71.
- R6: A read strobe with no write strobe since reset, and none in the same cycle, reports class 2'b10.
- R7: Write and read strobes in the same cycle count as a gap of 0 and report class 2'b00, in either state.
- R8: The gap counter saturates, so any gap longer than `NEW_MIN` still reports class 2'b01. For example, a gap of 1100 does not wrap into another window.
- R9: `viol_o` goes high in the same cycle as a class-2'b10 report. It then stays high until reset, and never rises without such a report.
- R10: Each read strobe is measured from the most recent write strobe. A later write strobe restarts the gap, and several read strobes after one write strobe each see their own gap.
- R11: The class code 2'b11 is never reported.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_rst_i | input | 1 | Write-pointer reset strobe |
| rd_rst_i | input | 1 | Read-pointer reset strobe |
| rpt_valid_o | output | 1 | One-cycle report pulse |
| rpt_class_o | output | 2 | 00 old, 01 new, 10 undetermined |
| viol_o | output | 1 | Sticky violation flag |

## Verification
The bench places read strobes at gaps of 69, 70, 71, 599 and 600 cycles, where an off-by-one compare would move a report into the wrong window and misreport, or miss, a violation. A gap of 1100 catches a counter that wraps instead of saturating, which would report undetermined. Same-cycle strobes are driven both before and after the first write strobe, so a design that ignores the same-cycle write would report undetermined or a stale gap. Repeated reads after a single write, and a write arriving between two reads, expose a counter that is cleared by the read strobe or is never restarted.

// File: rtl/frm_pkg.sv
package frm_pkg;
    typedef enum logic [1:0] {
        CLS_OLD   = 2'b00,
        CLS_NEW   = 2'b01,
        CLS_UNDEF = 2'b10
    } cls_e;

    typedef enum logic {
        ST_NOREF = 1'b0,
        ST_TRACK = 1'b1
    } st_e;
endpackage

// File: rtl/frm_gap_counter.sv
// Counts cycles since the last restart, holding at CAP.
module frm_gap_counter #(
    parameter int CAP   = 600,
    parameter int GAP_W = $clog2(CAP + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart_i,
    output logic [GAP_W-1:0] gap_o
);
    localparam logic [GAP_W-1:0] CAP_V = CAP[GAP_W-1:0];

    logic [GAP_W-1:0] gap_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else if (restart_i) begin
            gap_q <= GAP_W'(1);
        end else if (gap_q != CAP_V) begin
            gap_q <= gap_q + GAP_W'(1);
        end
    end

    // A restart in the current cycle means a gap of zero.
    assign gap_o = restart_i ? '0 : gap_q;
endmodule

// File: rtl/frm_gap_classifier.sv
// Sorts a gap into the old / undetermined / new windows.
module frm_gap_classifier
    import frm_pkg::*;
#(
    parameter int OLD_LIMIT = 70,
    parameter int NEW_MIN   = 600,
    parameter int GAP_W     = $clog2(NEW_MIN + 1)
) (
    input  logic             has_ref_i,
    input  logic [GAP_W-1:0] gap_i,
    output cls_e             cls_o
);
    localparam logic [GAP_W-1:0] OLD_V = OLD_LIMIT[GAP_W-1:0];
    localparam logic [GAP_W-1:0] NEW_V = NEW_MIN[GAP_W-1:0];

    always_comb begin
        if (!has_ref_i)          cls_o = CLS_UNDEF;
        else if (gap_i < OLD_V)  cls_o = CLS_OLD;
        else if (gap_i >= NEW_V) cls_o = CLS_NEW;
        else                     cls_o = CLS_UNDEF;
    end
endmodule

// File: rtl/frm_reset_monitor.sv
module frm_reset_monitor
    import frm_pkg::*;
#(
    parameter int OLD_LIMIT = 70,
    parameter int NEW_MIN   = 600
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_rst_i,
    input  logic       rd_rst_i,
    output logic       rpt_valid_o,
    output logic [1:0] rpt_class_o,
    output logic       viol_o
);
    localparam int GAP_W = $clog2(NEW_MIN + 1);

    st_e              state_q, state_d;
    logic [GAP_W-1:0] gap;
    logic             has_ref;
    cls_e             cls;

    frm_gap_counter #(.CAP(NEW_MIN), .GAP_W(GAP_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart_i (wr_rst_i),
        .gap_o     (gap)
    );

    // A same-cycle write strobe provides its own reference.
    assign has_ref = (state_q == ST_TRACK) || wr_rst_i;

    frm_gap_classifier #(
        .OLD_LIMIT (OLD_LIMIT),
        .NEW_MIN   (NEW_MIN),
        .GAP_W     (GAP_W)
    ) u_cls (
        .has_ref_i (has_ref),
        .gap_i     (gap),
        .cls_o     (cls)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_NOREF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_NOREF: if (wr_rst_i) state_d = ST_TRACK;
            ST_TRACK: state_d = ST_TRACK;
            default:  state_d = ST_NOREF;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rpt_valid_o <= 1'b0;
            rpt_class_o <= CLS_OLD;
            viol_o      <= 1'b0;
        end else begin
            rpt_valid_o <= rd_rst_i;
            if (rd_rst_i) begin
                rpt_class_o <= cls;
                if (cls == CLS_UNDEF) viol_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/frm_reset_monitor_chk.sv
module frm_reset_monitor_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_rst_i,
    input logic       rd_rst_i,
    input logic       rpt_valid_o,
    input logic [1:0] rpt_class_o,
    input logic       viol_o
);
    // R2: a report follows each read strobe
    a_r2_valid_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rst_i |=> rpt_valid_o);
    // R2: no report without a read strobe
    a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_rst_i |=> !rpt_valid_o);
    // R7: same-cycle strobes report old data
    a_r7_same_cycle_old: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rst_i && wr_rst_i) |=> (rpt_class_o == 2'b00));
    // R9: violation flag is sticky
    a_r9_viol_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        viol_o |=> viol_o);
    // R9: undetermined report sets the flag
    a_r9_undef_sets_viol: assert property (@(posedge clk) disable iff (!rst_n)
        (rpt_valid_o && rpt_class_o == 2'b10) |-> viol_o);
    // R9: flag rises only with an undetermined report
    a_r9_viol_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(viol_o) |-> (rpt_valid_o && rpt_class_o == 2'b10));
    // R11: code 11 never appears
    a_r11_no_code3: assert property (@(posedge clk) disable iff (!rst_n)
        rpt_valid_o |-> (rpt_class_o != 2'b11));
endmodule

bind frm_reset_monitor frm_reset_monitor_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_rst_i    (wr_rst_i),
    .rd_rst_i    (rd_rst_i),
    .rpt_valid_o (rpt_valid_o),
    .rpt_class_o (rpt_class_o),
    .viol_o      (viol_o)
);

// File: tb/frm_reset_monitor_bench.sv
`timescale 1ns/1ps
module frm_reset_monitor_bench;
    localparam int OLD_LIMIT = 70;
    localparam int NEW_MIN   = 600;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_rst_i = 1'b0;
    logic       rd_rst_i = 1'b0;
    logic       rpt_valid_o;
    logic [1:0] rpt_class_o;
    logic       viol_o;

    int n_run = 0;
    int n_fail = 0;

    bit has_ref = 0;
    int gap = 0;
    bit exp_viol = 0;
    bit done = 0;

    always #5 clk = ~clk;

    frm_reset_monitor #(.OLD_LIMIT(OLD_LIMIT), .NEW_MIN(NEW_MIN)) u_frm_reset_monitor (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_rst_i    (wr_rst_i),
        .rd_rst_i    (rd_rst_i),
        .rpt_valid_o (rpt_valid_o),
        .rpt_class_o (rpt_class_o),
        .viol_o      (viol_o)
    );

    function automatic logic [1:0] exp_cls(input bit ref_ok, input int g);
        if (!ref_ok)          return 2'b10;
        if (g < OLD_LIMIT)    return 2'b00;
        if (g >= NEW_MIN)     return 2'b01;
        return 2'b10;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One cycle with given strobes; checks the registered outputs after the edge.
    task automatic step(input bit wr, input bit rd, input string req);
        logic [1:0] ec;
        bit ref_now;
        int g_now;
        @(negedge clk);
        wr_rst_i = wr;
        rd_rst_i = rd;
        ref_now = has_ref || wr;
        g_now   = wr ? 0 : gap;
        ec      = exp_cls(ref_now, g_now);
        @(posedge clk);
        #2;
        if (wr) begin has_ref = 1; gap = 1; end
        else gap++;
        check({"R2 ", req}, rpt_valid_o, rd);
        if (rd) begin
            check(req, rpt_class_o, ec);
            if (ec == 2'b10) exp_viol = 1;
        end
        check({"R9 ", req}, viol_o, exp_viol);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            wr_rst_i = 0;
            rd_rst_i = 0;
            @(posedge clk);
            #2;
            gap++;
            if (rpt_valid_o) check("R2 idle", rpt_valid_o, 0);
            if (viol_o != exp_viol) check("R9 idle", viol_o, exp_viol);
        end
    endtask

    // Read strobe at exact gap g after a fresh write strobe.
    task automatic gap_read(input int g, input string req);
        step(1, 0, "write");
        idle(g - 1);
        step(0, 1, req);
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 0;
        wr_rst_i = 0;
        rd_rst_i = 0;
        @(posedge clk);
        #2;
        check("R1 valid in reset", rpt_valid_o, 0);
        check("R1 viol in reset", viol_o, 0);
        check("R1 class in reset", rpt_class_o, 0);
        @(negedge clk);
        rst_n = 1;
        has_ref = 0;
        gap = 0;
        exp_viol = 0;
        @(posedge clk);
        #2;
        check("R1 valid after reset", rpt_valid_o, 0);
        check("R1 viol after reset", viol_o, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        do_reset();
        step(0, 1, "R6 no reference");
        do_reset();
        step(1, 1, "R7 same cycle before ref");
        gap_read(69, "R3 gap 69");
        gap_read(600, "R4 gap 600");
        check("R9 still clear", viol_o, 0);
        step(1, 1, "R7 same cycle tracking");
        gap_read(1100, "R8 gap 1100");
        gap_read(599, "R5 gap 599");
        gap_read(70, "R5 gap 70");
        gap_read(71, "R5 gap 71");
        do_reset();
        step(1, 0, "write");
        idle(9);
        step(0, 1, "R10 first read gap 10");
        idle(59);
        step(0, 1, "R10 second read gap 70");
        step(1, 0, "R10 restart");
        idle(4);
        step(0, 1, "R10 read after restart gap 5");
        do_reset();
        for (int k = 0; k < 60; k++) begin
            int sel = $urandom_range(0, 3);
            int g;
            case (sel)
                0: g = $urandom_range(1, 80);
                1: g = $urandom_range(66, 75);
                2: g = $urandom_range(595, 605);
                default: g = $urandom_range(100, 900);
            endcase
            gap_read(g, "R3/R4/R5 random");
        end
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        #20;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule